// File: doc/BRIEF.md
# Page-Flip Frame Buffer Swap Controller

This block decides which colour buffer the scan-out logic shows and which one the renderer draws into. It owns three buffer slots and holds their indices internally. It drives a display base address that the scan-out engine uses as the address of pixel (0,0) of the shown frame. When the renderer finishes a frame it pulses `draw_done`. The flip itself is deferred until vertical blanking begins, so a frame is never replaced part-way through scan-out.

Two modes are offered. With double buffering, two slots alternate and the renderer is held off through `draw_ready` until the flip has happened. With triple buffering, the finished frame waits in a third slot and the renderer moves on at once. If a newer frame finishes before the blank arrives, it supersedes the waiting one. The images shown then trail the renderer by about two frames. The configuration inputs supply one base address per slot. The mode input is adopted only at a frame start while no flip is outstanding.

Top module: `fb_flip_ctrl`

## Requirements
- R1: After reset, `draw_idx` is 1, `draw_ready` is 1 and `disp_base` is 0. Slot 0 is the displayed slot, no flip is outstanding, and double mode is active.
- R2: `disp_base` changes only in the cycle after the first cycle of `vblank` high (a 0-to-1 transition). At that edge it loads the configured base of the slot displayed after any flip made in that same cycle. Slots 0, 1 and 2 map to `base0`, `base1` and `base2`.
- R3: In double mode, a `draw_done` accepted while `draw_ready` is high marks the drawn slot as pending. `draw_ready` is low from the next cycle until the flip commits.
- R4: In double mode, at the first cycle of vertical blank with a frame pending, the pending slot becomes the displayed slot. `draw_idx` becomes the previously displayed slot and `draw_ready` returns high.
- R5: In double mode, `draw_done` while `draw_ready` is low has no effect on any output.
- R6: In triple mode, `draw_ready` stays high. A `draw_done` with nothing pending moves `draw_idx` to the slot that is neither displayed nor being drawn.
- R7: In triple mode, a `draw_done` while a frame is already pending drops the older frame. `draw_idx` moves to the dropped slot, and the newest frame is the one shown at the next blank.
- R8: When `draw_done` coincides with the first cycle of vertical blank, the flip uses the frame that was already pending. The new frame then becomes pending. In triple mode, drawing continues in the slot that was displayed until then.
- R9: `mode_triple` (1 = triple, 0 = double) is taken only in a cycle with `frame_start` high, no frame pending and `draw_done` low. Otherwise the active mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame strobe from video timing |
| vblank | input | 1 | Vertical blanking level from video timing |
| mode_triple | input | 1 | Requested mode: 1 triple, 0 double |
| base0 | input | AW | Base address of slot 0 |
| base1 | input | AW | Base address of slot 1 |
| base2 | input | AW | Base address of slot 2 |
| draw_done | input | 1 | Renderer finished the frame in `draw_idx` |
| draw_ready | output | 1 | Renderer may draw into `draw_idx` |
| draw_idx | output | 2 | Slot the renderer draws into |
| disp_base | output | AW | Base address used by scan-out |

## Verification
The bench builds the block with its default 32-bit address width. It programs three distinct base values, so every slot assignment shows up directly as a distinct `disp_base` value. The stimulus reaches both modes and switching between them. It also covers rejected completions, superseded pending frames in triple mode, and completions that land on the very first blank cycle. A repeating pattern of completions against short blanking periods then drives every order of these events.

// File: rtl/fb_flip_ctrl.sv
module fb_flip_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          vblank,
  input  logic          mode_triple,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] base2,
  input  logic          draw_done,
  output logic          draw_ready,
  output logic [1:0]    draw_idx,
  output logic [AW-1:0] disp_base
);

  logic [1:0] disp_q, draw_q, pend_q;
  logic       pend_v, vb_q, triple_q;
  logic [1:0] disp_n, draw_n, pend_n;
  logic       pend_v_n;
  logic [AW-1:0] base_sel;

  wire vb_start = vblank & ~vb_q;
  wire commit   = vb_start & pend_v;
  wire accept   = draw_done & draw_ready;

  assign draw_ready = triple_q | ~pend_v;
  assign draw_idx   = draw_q;

  always_comb begin
    disp_n   = disp_q;
    draw_n   = draw_q;
    pend_n   = pend_q;
    pend_v_n = pend_v;
    if (commit) begin
      disp_n   = pend_q;
      pend_v_n = 1'b0;
      draw_n   = triple_q ? draw_q : disp_q;
    end
    if (accept) begin
      pend_n   = draw_q;
      pend_v_n = 1'b1;
      if (triple_q) begin
        if (commit)      draw_n = disp_q;
        else if (pend_v) draw_n = pend_q;
        else             draw_n = 2'd3 - disp_q - draw_q;
      end
    end
  end

  always_comb begin
    case (disp_n)
      2'd0:    base_sel = base0;
      2'd1:    base_sel = base1;
      default: base_sel = base2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q    <= 2'd0;
      draw_q    <= 2'd1;
      pend_q    <= 2'd0;
      pend_v    <= 1'b0;
      vb_q      <= 1'b0;
      triple_q  <= 1'b0;
      disp_base <= '0;
    end else begin
      disp_q <= disp_n;
      draw_q <= draw_n;
      pend_q <= pend_n;
      pend_v <= pend_v_n;
      vb_q   <= vblank;
      if (vb_start) disp_base <= base_sel;
      if (frame_start && !pend_v && !draw_done) triple_q <= mode_triple;
    end
  end

  p_base_only_vb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && !vb_q) |=> $stable(disp_base));

  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!triple_q && draw_done && draw_ready) |=> !draw_ready);

  p_disp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && !vb_q) |=> $stable(disp_q));

  p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!triple_q && !draw_ready && !(vblank && !vb_q)) |=> $stable(draw_idx));

  p_distinct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_q != draw_q);

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |=> $stable(triple_q));

endmodule

// File: tb/fb_flip_ctrl_bench.sv
module fb_flip_ctrl_bench;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, vblank = 0, mode_triple = 0, draw_done = 0;
  logic [AW-1:0] base0 = 32'h1000_0000, base1 = 32'h2000_0000, base2 = 32'h3000_0000;
  logic draw_ready;
  logic [1:0] draw_idx;
  logic [AW-1:0] disp_base;

  fb_flip_ctrl #(.AW(AW)) u_fb_flip_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .vblank(vblank),
    .mode_triple(mode_triple), .base0(base0), .base1(base1), .base2(base2),
    .draw_done(draw_done), .draw_ready(draw_ready), .draw_idx(draw_idx),
    .disp_base(disp_base));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done_flag = 0;

  // reference model
  int m_disp = 0, m_draw = 1, m_pend = 0, m_pv = 0, m_md = 0, m_vbq = 0;
  logic [AW-1:0] m_base = '0;

  function automatic logic [AW-1:0] slot_base(int s);
    return (s == 0) ? base0 : (s == 1) ? base1 : base2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_disp = 0; m_draw = 1; m_pend = 0; m_pv = 0; m_md = 0; m_vbq = 0; m_base = '0;
    end else begin
      int nd, ndr, np, npv, nmd;
      bit vr, acc, cm;
      vr  = vblank && (m_vbq == 0);
      cm  = vr && (m_pv != 0);
      acc = draw_done && (m_md != 0 || m_pv == 0);
      nd = m_disp; ndr = m_draw; np = m_pend; npv = m_pv; nmd = m_md;
      if (cm) begin
        nd = m_pend; npv = 0;
        if (m_md == 0) ndr = m_disp;
      end
      if (acc) begin
        np = m_draw; npv = 1;
        if (m_md != 0) begin
          if (cm) ndr = m_disp;
          else if (m_pv != 0) ndr = m_pend;
          else ndr = 3 - m_disp - m_draw;
        end
      end
      if (frame_start && m_pv == 0 && !draw_done) nmd = mode_triple ? 1 : 0;
      if (vr) m_base = slot_base(nd);
      m_disp = nd; m_draw = ndr; m_pend = np; m_pv = npv; m_md = nmd;
      m_vbq = vblank ? 1 : 0;
    end
  end

  task automatic check(string t, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(tag, "disp_base", disp_base, m_base);
      check(tag, "draw_idx", draw_idx, m_draw);
      check(tag, "draw_ready", draw_ready, (m_md != 0 || m_pv == 0) ? 1 : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic done_pulse();
    @(negedge clk) draw_done = 1;
    @(negedge clk) draw_done = 0;
  endtask
  task automatic fs_pulse();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask
  task automatic vb_pulse();
    @(negedge clk) vblank = 1;
    cyc(3);
    @(negedge clk) vblank = 0;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1", "reset draw_idx", draw_idx, 1);
    check("R1", "reset draw_ready", draw_ready, 1);
    check("R1", "reset disp_base", disp_base, 0);
    tag = "R2"; vb_pulse();
    check("R2", "base after idle blank", disp_base, base0);
    tag = "R3"; fs_pulse(); done_pulse(); cyc(2);
    check("R3", "ready low while pending", draw_ready, 0);
    tag = "R5"; done_pulse(); done_pulse(); cyc(2);
    check("R5", "draw_idx held", draw_idx, 1);
    tag = "R4"; vb_pulse();
    check("R4", "draw moves to old display", draw_idx, 0);
    check("R4", "base of flipped slot", disp_base, base1);
    tag = "R2"; base1 = 32'h2400_0000; cyc(2);
    check("R2", "base held mid-frame", disp_base, 32'h2000_0000);
    vb_pulse();
    check("R2", "base reloaded at blank", disp_base, 32'h2400_0000);
    tag = "R9"; mode_triple = 1; done_pulse(); fs_pulse(); vb_pulse();
    @(negedge clk) begin frame_start = 1; draw_done = 1; end
    @(negedge clk) begin frame_start = 0; draw_done = 0; end
    vb_pulse(); fs_pulse();
    tag = "R6"; done_pulse(); cyc(1);
    check("R6", "ready stays high", draw_ready, 1);
    tag = "R7"; done_pulse(); done_pulse(); cyc(2); vb_pulse();
    tag = "R8"; done_pulse(); cyc(2);
    @(negedge clk) begin draw_done = 1; vblank = 1; end
    @(negedge clk) draw_done = 0;
    cyc(2); @(negedge clk) vblank = 0; vb_pulse();
    tag = "R9"; mode_triple = 0; done_pulse(); fs_pulse(); vb_pulse(); fs_pulse();
    tag = "R8"; done_pulse();
    @(negedge clk) begin draw_done = 1; vblank = 1; end
    @(negedge clk) draw_done = 0;
    cyc(2); @(negedge clk) vblank = 0; vb_pulse();
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      draw_done   = (i % 3 == 0) || (i % 7 == 2);
      vblank      = (i % 11) < 3;
      frame_start = (i % 11) == 5;
      if (i % 97 == 0) mode_triple = ~mode_triple;
    end
    @(negedge clk) begin draw_done = 0; vblank = 0; frame_start = 0; end
    cyc(4);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule